// File: doc/BRIEF.md
# SDRAM Command Issuer with Forced-Command Modes and Idle Page Closing

This block sits between a memory arbiter and the command pins of an SDRAM device with two internal banks. For each accepted request it issues the shortest legal command sequence. A request to a row that is already open gets a single read or write. A request to a closed bank gets an activate and then the access. A request to a bank holding a different row gets a precharge, an activate and then the access. The block remembers which row is open in each bank. When no request arrives for a fixed number of clocks, it closes all open rows.

A 16-bit control register, written by software, holds a command-override field. While initialization firmware sets that field to a non-normal value, the block ignores requests and drives one fixed command on every cycle: no-operation, precharge of all banks, load of the device mode register, or auto refresh. Firmware steps through these codes to bring up the memory. It then returns the field to normal. The register also holds an idle-timeout selector and a close-policy selector. Only their zero codes are defined, and every code of either field behaves like zero.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: After synchronous reset the pins show a no-operation (row strobe, column strobe and write enable all 1), the bank address and the precharge-all line are 0, the register reads 0000h, and `req_ready` is 1.
- R2: Bits 7:5 (override mode), 3:2 (timeout select) and 1:0 (close policy) of the control register read back as written. Bits 15:8 and bit 4 always read 0. A write is visible on `cfg_rdata` in the cycle after it.
- R3: While the mode field is 001 and the block is waiting for a request, every command is a no-operation (1,1,1) and `req_ready` is 0.
- R4: Mode 010 drives precharge-all (0,1,0) with A10 high on every waiting cycle, with `req_ready` 0. Afterwards both banks count as closed, so the next request to either bank begins with an activate.
- R5: Mode 011 drives the mode-register-set command (0,0,0) on every waiting cycle, with `req_ready` 0.
- R6: Mode 100 drives the refresh command (0,0,1) on every waiting cycle, with `req_ready` 0.
- R7: Mode codes 101, 110 and 111 behave exactly like 000: requests are accepted and sequenced normally.
- R8: Normal sequencing uses these encodings for (row strobe, column strobe, write enable): activate 0,1,1; read 1,0,1; write 1,0,0; precharge 0,1,0; idle 1,1,1. A request accepted in cycle t shows its first command on the pins in cycle t+1. Each following command of the sequence appears one cycle after the one before it. A closed bank gets activate then access. A hit on the open row gets the access alone.
- R9: A page miss without an arbitration switch gives a precharge of that bank only (A10 low, bank address equal to the requested bank), then activate, then access. The other bank keeps its open row.
- R10: A page miss with `arb_switch` high gives a precharge with A10 high, which closes both banks, then activate, then access.
- R11: With any bank open and no request, the timer counts waiting cycles, starting from 0. After 16 such cycles, the next waiting cycle issues precharge-all (A10 high, bank 0) and closes both banks. The 16 idle cycles show 16 idle commands on the pins, and the precharge appears as the 17th. An accepted request, or any cycle outside the waiting state, restarts the count at 0.
- R12: A mode write takes effect from the next waiting cycle. A sequence already in progress finishes its activate and access before any forced command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read data |
| req_valid | input | 1 | Memory request present |
| req_bank | input | BANK_W (1) | Requested bank |
| req_row | input | ROW_W (12) | Requested row |
| req_write | input | 1 | 1 for write, 0 for read |
| arb_switch | input | 1 | The request comes from a different arbitration winner |
| req_ready | output | 1 | The request is taken in this cycle if `req_valid` is high |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W (1) | Bank address of the command |
| a10 | output | 1 | High for a precharge of all banks |

## Verification
Row tracking is internal, so a wrong open flag or a wrong stored row shows up on the pins at the next request to that bank. There the first command is wrong: an access instead of an activate, or a precharge that should be absent. The bench keeps its own model of the open rows and checks every command of every sequence against it. It also checks that the idle-close precharge lands exactly in the 17th idle cycle, counted both from an activate and from a hit. A count off by one cycle therefore fails at once. A mode decoded on the wrong cycle appears either as a forced code inside a running sequence or as a forced code that arrives late.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    // Command encoding, field order ras_n, cas_n, we_n.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_IDLE  = 3'b111;
    localparam cmd_t CMD_ACT   = 3'b011;
    localparam cmd_t CMD_READ  = 3'b101;
    localparam cmd_t CMD_WRITE = 3'b100;
    localparam cmd_t CMD_PRE   = 3'b010;
    localparam cmd_t CMD_MRS   = 3'b000;
    localparam cmd_t CMD_REF   = 3'b001;

    // Override mode codes (register bits 7:5).
    localparam logic [2:0] OVR_NORMAL = 3'b000;
    localparam logic [2:0] OVR_IDLE   = 3'b001;
    localparam logic [2:0] OVR_PREALL = 3'b010;
    localparam logic [2:0] OVR_MRS    = 3'b011;
    localparam logic [2:0] OVR_REF    = 3'b100;

    // Register field positions that software depends on.
    localparam int MODE_LSB = 5;
    localparam int TMO_LSB  = 2;
    localparam int POL_LSB  = 0;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_ACT  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    function automatic logic ovr_active(input logic [2:0] mode);
        return (mode == OVR_IDLE) || (mode == OVR_PREALL) ||
               (mode == OVR_MRS)  || (mode == OVR_REF);
    endfunction

    function automatic cmd_t ovr_cmd(input logic [2:0] mode);
        cmd_t c;
        unique case (mode)
            OVR_PREALL: c = CMD_PRE;
            OVR_MRS:    c = CMD_MRS;
            OVR_REF:    c = CMD_REF;
            default:    c = CMD_IDLE;
        endcase
        return c;
    endfunction

    function automatic cmd_t access_cmd(input logic is_write);
        return is_write ? CMD_WRITE : CMD_READ;
    endfunction

endpackage

// File: rtl/sdram_ctl_reg.sv
module sdram_ctl_reg
    import sdram_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic [2:0]  mode
);
    logic [2:0] mode_q;
    logic [1:0] tmo_q;
    logic [1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OVR_NORMAL;
            tmo_q  <= 2'b00;
            pol_q  <= 2'b00;
        end else if (wr_en) begin
            mode_q <= wr_data[MODE_LSB +: 3];
            tmo_q  <= wr_data[TMO_LSB +: 2];
            pol_q  <= wr_data[POL_LSB +: 2];
        end
    end

    // Timeout and policy codes are stored for readback only; every code acts as 00.
    always_comb begin
        rd_data                = '0;
        rd_data[MODE_LSB +: 3] = mode_q;
        rd_data[TMO_LSB +: 2]  = tmo_q;
        rd_data[POL_LSB +: 2]  = pol_q;
    end

    assign mode = mode_q;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15:8] == 8'h00) && (rd_data[4] == 1'b0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[7:5] == $past(wr_data[7:5])));

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             is_open,
    output logic             row_match
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (close) begin
            open_q <= 1'b0;
        end
    end

    assign is_open   = open_q;
    assign row_match = (row_q == probe_row);

    a_r10_close_takes: assert property (@(posedge clk) disable iff (rst)
        (close && !open_set) |=> !is_open);

endmodule

// File: rtl/sdram_idle_timer.sv
module sdram_idle_timer #(
    parameter int IDLE_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fire
);
    localparam int CW = $clog2(IDLE_CLKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CLKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || cnt_q == LIMIT) cnt_q <= '0;
        else                               cnt_q <= cnt_q + 1'b1;
    end

    assign fire = run && (cnt_q == LIMIT);

    a_r11_count_cap: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    a_r11_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int NBANK     = 2,
    parameter int IDLE_CLKS = 16,
    localparam int BANK_W   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              arb_switch,
    output logic              req_ready,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic              a10
);
    logic [2:0] mode;
    logic       forcing;

    sdram_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .mode    (mode)
    );

    assign forcing = ovr_active(mode);

    seq_state_t        state_q, state_d;
    logic [BANK_W-1:0] pend_bank_q;
    logic [ROW_W-1:0]  pend_row_q;
    logic              pend_wr_q;
    logic              take;

    logic [NBANK-1:0]  open_v, hit_v, set_v, close_v;
    logic [ROW_W-1:0]  set_row;

    assign set_row = (state_q == ST_WAIT) ? req_row : pend_row_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdram_bank_track #(.ROW_W(ROW_W)) u_trk (
            .clk       (clk),
            .rst       (rst),
            .open_set  (set_v[b]),
            .close     (close_v[b]),
            .set_row   (set_row),
            .probe_row (req_row),
            .is_open   (open_v[b]),
            .row_match (hit_v[b])
        );
    end

    logic tmr_run, tmr_fire;

    assign req_ready = (state_q == ST_WAIT) && !forcing;
    assign tmr_run   = req_ready && !req_valid && (|open_v);

    sdram_idle_timer #(.IDLE_CLKS(IDLE_CLKS)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (tmr_run),
        .fire (tmr_fire)
    );

    cmd_t              cmd_d, cmd_q;
    logic [BANK_W-1:0] ba_d, ba_q;
    logic              a10_d, a10_q;

    always_comb begin
        cmd_d   = CMD_IDLE;
        ba_d    = '0;
        a10_d   = 1'b0;
        state_d = state_q;
        set_v   = '0;
        close_v = '0;
        take    = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (forcing) begin
                    cmd_d = ovr_cmd(mode);
                    if (mode == OVR_PREALL) begin
                        a10_d   = 1'b1;
                        close_v = '1;
                    end
                end else if (req_valid) begin
                    take = 1'b1;
                    ba_d = req_bank;
                    if (open_v[req_bank] && hit_v[req_bank]) begin
                        cmd_d = access_cmd(req_write);
                    end else if (open_v[req_bank]) begin
                        cmd_d   = CMD_PRE;
                        a10_d   = arb_switch;
                        state_d = ST_ACT;
                        if (arb_switch) close_v = '1;
                        else            close_v[req_bank] = 1'b1;
                    end else begin
                        cmd_d            = CMD_ACT;
                        set_v[req_bank]  = 1'b1;
                        state_d          = ST_XFER;
                    end
                end else if (tmr_fire) begin
                    cmd_d   = CMD_PRE;
                    a10_d   = 1'b1;
                    close_v = '1;
                end
            end
            ST_ACT: begin
                cmd_d              = CMD_ACT;
                ba_d               = pend_bank_q;
                set_v[pend_bank_q] = 1'b1;
                state_d            = ST_XFER;
            end
            ST_XFER: begin
                cmd_d   = access_cmd(pend_wr_q);
                ba_d    = pend_bank_q;
                state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_WAIT;
            pend_bank_q <= '0;
            pend_row_q  <= '0;
            pend_wr_q   <= 1'b0;
            cmd_q       <= CMD_IDLE;
            ba_q        <= '0;
            a10_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            ba_q    <= ba_d;
            a10_q   <= a10_d;
            if (take) begin
                pend_bank_q <= req_bank;
                pend_row_q  <= req_row;
                pend_wr_q   <= req_write;
            end
        end
    end

    assign ras_n = cmd_q.ras_n;
    assign cas_n = cmd_q.cas_n;
    assign we_n  = cmd_q.we_n;
    assign ba    = ba_q;
    assign a10   = a10_q;

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cmd_q == CMD_IDLE && !a10_q));

    a_r3_idle_only: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && mode == OVR_IDLE) |=> (cmd_q == CMD_IDLE));

    a_r8_act_then_access: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |=> (!cas_n && ras_n));

    a_r10_switch_miss_closes_all: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && arb_switch && open_v[req_bank] && !hit_v[req_bank])
        |=> (cmd_q == CMD_PRE && a10_q));

    a_r11_timeout_prech: assert property (@(posedge clk) disable iff (rst)
        tmr_fire |=> (cmd_q == CMD_PRE && a10_q && open_v == '0));

    a_r12_seq_intact: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_WAIT) |=> (cmd_q == CMD_ACT || cmd_q == CMD_READ || cmd_q == CMD_WRITE));

endmodule

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [0:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic        req_write = 1'b0;
    logic        arb_switch = 1'b0;
    logic        req_ready;
    logic        ras_n, cas_n, we_n;
    logic [0:0]  ba;
    logic        a10;

    int checks = 0;
    int errs   = 0;

    // Bench model of the open rows.
    bit          m_open [2];
    logic [11:0] m_row  [2];

    localparam logic [2:0] P_IDLE = 3'b111, P_ACT = 3'b011, P_RD = 3'b101,
                           P_WR = 3'b100, P_PRE = 3'b010, P_MRS = 3'b000, P_REF = 3'b001;

    always #10 clk = ~clk;

    sdram_cmd_issuer uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row), .req_write(req_write),
        .arb_switch(arb_switch), .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_pins(input string tag, input logic [2:0] ec, input logic eba, input logic ea10);
        checks++;
        if ({ras_n, cas_n, we_n} !== ec || ba !== eba || a10 !== ea10) begin
            errs++;
            $display("FAIL %s: pins=%b ba=%0d a10=%b, expected pins=%b ba=%0d a10=%b",
                     tag, {ras_n, cas_n, we_n}, ba, a10, ec, eba, ea10);
        end
    endtask

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h, expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    // Drives one request and checks the full command sequence against the model.
    task automatic expect_req(input string tag, input logic b, input logic [11:0] r,
                              input logic w, input logic sw);
        logic [2:0] acc;
        acc = w ? P_WR : P_RD;
        req_valid = 1'b1; req_bank = b; req_row = r; req_write = w; arb_switch = sw;
        step();
        req_valid = 1'b0; arb_switch = 1'b0;
        if (m_open[b] && m_row[b] == r) begin
            check_pins({tag, " hit access"}, acc, b, 1'b0);
        end else begin
            if (m_open[b]) begin
                check_pins({tag, " miss precharge"}, P_PRE, b, sw);
                if (sw) begin m_open[0] = 0; m_open[1] = 0; end
                else m_open[b] = 0;
                step();
            end
            check_pins({tag, " activate"}, P_ACT, b, 1'b0);
            m_open[b] = 1; m_row[b] = r;
            step();
            check_pins({tag, " access"}, acc, b, 1'b0);
        end
    endtask

    initial begin
        m_open[0] = 0; m_open[1] = 0; m_row[0] = '0; m_row[1] = '0;
        step(); step();
        rst = 1'b0;
        // R1: reset state
        check_pins("R1 reset pins", P_IDLE, 1'b0, 1'b0);
        check_val("R1 reset register", {16'h0, cfg_rdata}, 32'h0);
        check_val("R1 reset ready", {31'h0, req_ready}, 32'h1);

        // R2: readback sweep over every low byte value
        for (int v = 0; v < 256; v++) begin
            write_cfg({8'(v) ^ 8'hA5, 8'(v)});
            check_val("R2 readback", {16'h0, cfg_rdata}, {16'h0, 8'h00, 8'(v) & 8'hEF});
        end
        write_cfg(16'h0000);
        step();

        // R8: normal sequencing on closed banks and hits
        expect_req("R8 b0 closed", 1'b0, 12'h005, 1'b0, 1'b0);
        expect_req("R8 b0 hit write", 1'b0, 12'h005, 1'b1, 1'b0);
        expect_req("R8 b1 closed", 1'b1, 12'h009, 1'b0, 1'b0);
        expect_req("R8 b1 hit read", 1'b1, 12'h009, 1'b0, 1'b1);
        // R9: miss without switch closes only that bank
        expect_req("R9 b0 miss", 1'b0, 12'h006, 1'b0, 1'b0);
        expect_req("R9 b1 kept open", 1'b1, 12'h009, 1'b1, 1'b0);
        // R10: miss with switch closes both banks
        expect_req("R10 b1 miss switch", 1'b1, 12'h003, 1'b0, 1'b1);
        expect_req("R10 b0 closed after", 1'b0, 12'h006, 1'b0, 1'b0);

        // R11: 16 idle cycles then precharge-all
        for (int k = 1; k <= 16; k++) begin
            step();
            check_pins("R11 idle before timeout", P_IDLE, 1'b0, 1'b0);
        end
        step();
        check_pins("R11 timeout precharge", P_PRE, 1'b0, 1'b1);
        m_open[0] = 0; m_open[1] = 0;
        step();
        check_pins("R11 single precharge", P_IDLE, 1'b0, 1'b0);

        // R12: mode write during a sequence does not cut it
        req_valid = 1'b1; req_bank = 1'b1; req_row = 12'h00B; req_write = 1'b0;
        step();
        req_valid = 1'b0;
        check_pins("R12 activate", P_ACT, 1'b1, 1'b0);
        m_open[1] = 1; m_row[1] = 12'h00B;
        write_cfg(16'h0060);
        check_pins("R12 access completes", P_RD, 1'b1, 1'b0);
        step();
        check_pins("R12 forced after sequence", P_MRS, 1'b0, 1'b0);
        write_cfg(16'h0000);
        step();
        check_pins("R12 normal again", P_IDLE, 1'b0, 1'b0);

        // R11: a request restarts the idle count
        for (int k = 0; k < 10; k++) step();
        expect_req("R11 restart hit", 1'b1, 12'h00B, 1'b0, 1'b0);
        for (int k = 1; k <= 16; k++) begin
            step();
            check_pins("R11 idle after restart", P_IDLE, 1'b0, 1'b0);
        end
        step();
        check_pins("R11 timeout after restart", P_PRE, 1'b0, 1'b1);
        m_open[0] = 0; m_open[1] = 0;

        // R3..R7: sweep all mode codes
        expect_req("R4 setup open b0", 1'b0, 12'h020, 1'b0, 1'b0);
        for (int m = 0; m < 8; m++) begin
            logic [2:0] mc;
            mc = 3'(m);
            write_cfg({8'h00, mc, 5'b0});
            step();
            if (m >= 1 && m <= 4) begin
                req_valid = 1'b1; req_bank = 1'b1; req_row = 12'h0F0; req_write = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    check_val($sformatf("R%0d ready low mode %0d", m + 2, m), {31'h0, req_ready}, 32'h0);
                    if (m == 1) check_pins("R3 forced idle", P_IDLE, 1'b0, 1'b0);
                    if (m == 2) check_pins("R4 forced precharge-all", P_PRE, 1'b0, 1'b1);
                    if (m == 3) check_pins("R5 forced mode set", P_MRS, 1'b0, 1'b0);
                    if (m == 4) check_pins("R6 forced refresh", P_REF, 1'b0, 1'b0);
                    step();
                end
                req_valid = 1'b0;
                if (m == 2) begin m_open[0] = 0; m_open[1] = 0; end
                write_cfg(16'h0000);
                step();
                expect_req($sformatf("R4 bank state after mode %0d", m), 1'b0, 12'h020, 1'b0, 1'b0);
            end else begin
                check_val($sformatf("R7 ready mode %0d", m), {31'h0, req_ready}, 32'h1);
                expect_req($sformatf("R7 normal mode %0d", m), 1'b1, 12'(12'h050 + m), mc[0], 1'b1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule